// File: doc/BRIEF.md
# Windowed Threshold-Crossing Signal Monitor

This block watches one converter channel and condenses its activity into one number per measurement window. Each incoming two's-complement sample is turned into its magnitude. Depending on the selected mode, the block then counts the samples whose magnitude lies strictly above a programmable threshold, or it tracks the largest magnitude seen. A reloading down-counter, clocked every cycle, sets how long each window lasts. At the close of a window, the chosen figure is copied into a holding register, a one-cycle strobe announces it, and both running figures start again from zero.

A system places one instance per channel. It programs the window length, the threshold and the mode, and it may pulse the sync input to align the windows to an external event, for example across several channels. The result stays in the holding register until the next window closes, so a slower consumer can pick it up at leisure.

Top module: `smon_window_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `result` is zero and `resultValid` is low until the first window closes.
- R2: A window lasts exactly `periodLen` clock cycles. The counter loads `periodLen` on the cycle after reset release or after a sync, counts down once per cycle, and closes the window on the cycle in which it holds one. It reloads from the `periodLen` value present in that closing cycle. `resultValid` is high for one cycle, the cycle after the closing cycle, and `result` changes in that same cycle.
- R3: With `mode` = 2'b10 (crossing count), the result is the number of samples in the window that have `sampleValid` high and a magnitude strictly greater than `threshold`. Samples with `sampleValid` low do not count.
- R4: The magnitude is the absolute value of the two's-complement `sampleData`, zero-extended to SAMPLE_W+1 bits. The most negative code gives 2^(SAMPLE_W-1), which is 2048 by default.
- R5: With `mode` = 2'b01 (peak), the result is the largest magnitude among the valid samples of the window, zero-extended to RESULT_W bits. It is 0 if the window had no valid sample.
- R6: Both running figures clear at each window close, so a result reflects only the samples of its own window.
- R7: The crossing count saturates at all ones (2^RESULT_W - 1) and never wraps.
- R8: A cycle with `syncPulse` high reloads the counter and clears both running figures without updating `result` or pulsing `resultValid`. The sample in that cycle is discarded, and a full window starts on the next cycle.
- R9: With `mode` = 2'b00 or 2'b11, no window close raises `resultValid` or changes `result`.
- R10: With `periodLen` = 0, no window ever closes and `resultValid` stays low.
- R11: `result` keeps its value in every cycle in which `resultValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; the window is counted in these cycles |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleData` in this cycle |
| sampleData | input | SAMPLE_W | Two's-complement sample |
| periodLen | input | PERIOD_W | Window length in cycles; 0 stops window closes |
| threshold | input | SAMPLE_W+1 | Unsigned magnitude threshold for crossing count |
| mode | input | 2 | 01 peak, 10 crossing count, 00/11 no reporting |
| syncPulse | input | 1 | Restarts the window and discards the running figures |
| result | output | RESULT_W | Holding register with the last reported figure |
| resultValid | output | 1 | One-cycle strobe when `result` is refreshed |

## Verification
The assertions assume that `mode` is held steady from the closing cycle of a window into the following cycle. They also assume that `periodLen` is a stable level rather than a value that changes every cycle, because the reload and sync properties compare it with the counter one cycle later. The stimulus meets both conditions by changing mode and window length only on falling edges between windows, or at a chosen point whose effect is worked out in advance. Sync is driven as a single-cycle pulse. A second, narrow instance brings the count saturation within reach of a short run.

// File: rtl/smon_pkg.sv
package smon_pkg;

  // Reporting selection; the two unnamed codes leave the holding register untouched
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_PEAK  = 2'b01,
    MODE_COUNT = 2'b10,
    MODE_OFF2  = 2'b11
  } monMode_e;

  // Strobes handed from the window control to the datapath
  typedef struct packed {
    logic restart;    // drop running figures, no report
    logic windowEnd;  // last cycle of a window: report, then drop
  } winStrobe_t;

endpackage

// File: rtl/smon_magnitude.sv
module smon_magnitude #(
  parameter int SAMPLE_W = 12,
  localparam int MAG_W   = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [MAG_W-1:0]    magnitude
);

  logic [MAG_W-1:0] signExt;

  always_comb begin
    signExt = {sampleData[SAMPLE_W-1], sampleData};
    if (signExt[MAG_W-1]) begin
      magnitude = (~signExt) + MAG_W'(1);
    end else begin
      magnitude = signExt;
    end
  end

endmodule

// File: rtl/smon_window_ctrl.sv
module smon_window_ctrl
  import smon_pkg::*;
#(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncPulse,
  input  logic [PERIOD_W-1:0] periodLen,
  output winStrobe_t          strobes
);

  localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] winCount;

  // A zero count means "not loaded yet" (after reset or with a zero period)
  always_comb begin
    strobes.restart   = syncPulse || (winCount == '0);
    strobes.windowEnd = !syncPulse && (winCount == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCount <= '0;
    end else if (strobes.restart || strobes.windowEnd) begin
      winCount <= periodLen;
    end else begin
      winCount <= winCount - CNT_ONE;
    end
  end

  // R2: a closing window reloads from the length seen at the close
  p_reload_on_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.windowEnd |=> (winCount == $past(periodLen)));

  // R8: after a sync, a window longer than one cycle cannot close at once
  p_sync_defers_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncPulse && (periodLen > CNT_ONE)) |=> !strobes.windowEnd);

  // R10: a zero length keeps the counter from ever closing a window
  p_zero_period_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.restart && (periodLen == '0)) |=> !strobes.windowEnd);

endmodule

// File: rtl/smon_datapath.sv
module smon_datapath
  import smon_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 20,
  localparam int MAG_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [MAG_W-1:0]    threshold,
  input  monMode_e            mode,
  input  winStrobe_t          strobes,
  output logic [RESULT_W-1:0] result,
  output logic                resultValid
);

  localparam logic [RESULT_W-1:0] COUNT_SAT = '1;
  localparam int                  MAX_MAG   = 1 << (SAMPLE_W - 1);

  logic [MAG_W-1:0]    magnitude;
  logic [MAG_W-1:0]    peakAcc;
  logic [MAG_W-1:0]    peakNext;
  logic [RESULT_W-1:0] countAcc;
  logic [RESULT_W-1:0] countNext;
  logic [RESULT_W-1:0] reportVal;
  logic                crossing;
  logic                reportEn;
  logic                dropAcc;

  smon_magnitude #(.SAMPLE_W(SAMPLE_W)) magnitude_i (
    .sampleData (sampleData),
    .magnitude  (magnitude)
  );

  always_comb begin
    crossing  = sampleValid && (magnitude > threshold);
    peakNext  = (sampleValid && (magnitude > peakAcc)) ? magnitude : peakAcc;
    countNext = (crossing && (countAcc != COUNT_SAT)) ? countAcc + RESULT_W'(1)
                                                      : countAcc;
    dropAcc   = strobes.restart || strobes.windowEnd;
    unique case (mode)
      MODE_PEAK: begin
        reportVal = RESULT_W'(peakNext);
        reportEn  = strobes.windowEnd;
      end
      MODE_COUNT: begin
        reportVal = countNext;
        reportEn  = strobes.windowEnd;
      end
      default: begin
        reportVal = result;
        reportEn  = 1'b0;
      end
    endcase
  end

  // Running figures: both kept so a mode change only affects the next report
  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakAcc  <= '0;
      countAcc <= '0;
    end else if (dropAcc) begin
      peakAcc  <= '0;
      countAcc <= '0;
    end else begin
      peakAcc  <= peakNext;
      countAcc <= countNext;
    end
  end

  // Holding register and its strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= reportEn;
      if (reportEn) begin
        result <= reportVal;
      end
    end
  end

  // R7: inside a window the count never steps backwards (no wrap)
  p_count_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dropAcc |=> (countAcc >= $past(countAcc)));

  // R11: the holding register is quiet between strobes
  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R4: a reported peak never exceeds the largest possible magnitude
  p_peak_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && ($past(mode) == MODE_PEAK)) |-> (result <= RESULT_W'(MAX_MAG)));

  // R9: a strobe only follows a close in a reporting mode
  p_strobe_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (($past(mode) == MODE_PEAK) || ($past(mode) == MODE_COUNT)));

endmodule

// File: rtl/smon_window_monitor.sv
module smon_window_monitor
  import smon_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 20,
  parameter int PERIOD_W = 24,
  localparam int MAG_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [PERIOD_W-1:0] periodLen,
  input  logic [MAG_W-1:0]    threshold,
  input  logic [1:0]          mode,
  input  logic                syncPulse,
  output logic [RESULT_W-1:0] result,
  output logic                resultValid
);

  winStrobe_t strobes;
  monMode_e   modeSel;

  assign modeSel = monMode_e'(mode);

  smon_window_ctrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .syncPulse (syncPulse),
    .periodLen (periodLen),
    .strobes   (strobes)
  );

  smon_datapath #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W)) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .threshold   (threshold),
    .mode        (modeSel),
    .strobes     (strobes),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: tb/smon_window_monitor_tb.sv
`timescale 1ns/1ps
module smon_window_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sv;
  logic [11:0] sd;
  logic [23:0] pl;
  logic [12:0] thr;
  logic [1:0]  md;
  logic        sy;
  logic [19:0] res;
  logic        rv;

  // narrow instance used for the saturation case
  logic        sv2;
  logic [3:0]  sd2;
  logic [7:0]  pl2;
  logic [4:0]  thr2;
  logic [1:0]  md2;
  logic        sy2;
  logic [5:0]  res2;
  logic        rv2;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int lastRes = 0;

  logic [11:0] wData  [16];
  logic        wValid [16];

  always #4 clk = ~clk;

  smon_window_monitor dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sv), .sampleData(sd), .periodLen(pl),
    .threshold(thr), .mode(md), .syncPulse(sy), .result(res), .resultValid(rv)
  );

  smon_window_monitor #(.SAMPLE_W(4), .RESULT_W(6), .PERIOD_W(8)) dutSat_i (
    .clk(clk), .rstN(rstN), .sampleValid(sv2), .sampleData(sd2), .periodLen(pl2),
    .threshold(thr2), .mode(md2), .syncPulse(sy2), .result(res2), .resultValid(rv2)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int absOf(input logic [11:0] s);
    return s[11] ? 4096 - int'(s) : int'(s);
  endfunction

  function automatic int expectFor(input int n, input logic [1:0] mdv, input int thrv);
    int acc = 0;
    for (int i = 0; i < n; i++) begin
      if (wValid[i]) begin
        if (mdv == 2'b01 && absOf(wData[i]) > acc) acc = absOf(wData[i]);
        if (mdv == 2'b10 && absOf(wData[i]) > thrv) acc++;
      end
    end
    return acc;
  endfunction

  task automatic setW(input int i, input int val, input bit v);
    wData[i]  = 12'(val);
    wValid[i] = v;
  endtask

  // Single sync pulse; returns at the falling edge after the restart edge
  task automatic syncStart();
    @(negedge clk);
    sy = 1'b1;
    sv = 1'b0;
    @(negedge clk);
    sy = 1'b0;
  endtask

  // Drives n samples, one per cycle, then checks strobe and result
  task automatic feedWindow(input int n, input string req, input bit expStrobe, input int expRes);
    int early = 0;
    for (int i = 0; i < n; i++) begin
      sd = wData[i];
      sv = wValid[i];
      @(negedge clk);
      if (i < n - 1 && rv) early++;
    end
    sv = 1'b0;
    check(req, early, 0, "strobe inside window");
    check(req, int'(rv), int'(expStrobe), "strobe at close");
    check(req, int'(res), expRes, "result");
    if (expStrobe) lastRes = expRes;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", int'(rv), 0, "strobe in reset");
    check("R1", int'(res), 0, "result in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(rv), 0, "strobe after release");
    check("R1", int'(res), 0, "result after release");
  endtask

  task automatic testCount();
    md = 2'b10; thr = 13'd100; pl = 24'd8;
    setW(0, 101, 1); setW(1, 100, 1); setW(2, -101, 1); setW(3, -100, 1);
    setW(4, 2047, 1); setW(5, 0, 1); setW(6, 500, 0); setW(7, -2048, 1);
    syncStart();
    feedWindow(8, "R3", 1'b1, expectFor(8, 2'b10, 100));
  endtask

  task automatic testPeak();
    md = 2'b01; pl = 24'd8;
    setW(0, -5, 1); setW(1, 300, 1); setW(2, -2048, 0); setW(3, -700, 1);
    setW(4, 12, 1); setW(5, 0, 1); setW(6, 699, 1); setW(7, 1, 1);
    syncStart();
    feedWindow(8, "R5", 1'b1, expectFor(8, 2'b01, 0));
    // R4: most negative code, back-to-back window
    setW(2, -2048, 1);
    feedWindow(8, "R4", 1'b1, 2048);
    // R5: no valid sample in the window
    for (int i = 0; i < 8; i++) wValid[i] = 1'b0;
    feedWindow(8, "R5", 1'b1, 0);
  endtask

  task automatic testBackToBack();
    md = 2'b10; thr = 13'd10; pl = 24'd8;
    for (int i = 0; i < 8; i++) setW(i, 50, 1);
    syncStart();
    feedWindow(8, "R6", 1'b1, 8);
    for (int i = 0; i < 8; i++) setW(i, (i < 3) ? -60 : 3, 1);
    feedWindow(8, "R6", 1'b1, 3);
  endtask

  task automatic testReloadLength();
    md = 2'b10; thr = 13'd10; pl = 24'd8;
    for (int i = 0; i < 8; i++) setW(i, 20, 1);
    syncStart();
    pl = 24'd5;  // counter already holds 8; new length applies at the next reload
    feedWindow(8, "R2", 1'b1, 8);
    feedWindow(5, "R2", 1'b1, 5);
  endtask

  task automatic testSync();
    md = 2'b10; thr = 13'd10; pl = 24'd8;
    syncStart();
    for (int i = 0; i < 3; i++) begin
      sd = 12'd50; sv = 1'b1;
      @(negedge clk);
    end
    sy = 1'b1; sd = 12'd50; sv = 1'b1;  // this sample must be discarded
    @(negedge clk);
    sy = 1'b0;
    check("R8", int'(rv), 0, "no strobe on sync");
    check("R8", int'(res), lastRes, "result kept on sync");
    for (int i = 0; i < 8; i++) setW(i, (i % 2 == 0) ? 40 : 2, 1);
    feedWindow(8, "R8", 1'b1, 4);
  endtask

  task automatic testIdleModes();
    thr = 13'd10; pl = 24'd8;
    for (int i = 0; i < 8; i++) setW(i, 77, 1);
    md = 2'b00;
    syncStart();
    feedWindow(8, "R9", 1'b0, lastRes);
    md = 2'b11;
    feedWindow(8, "R11", 1'b0, lastRes);
  endtask

  task automatic testZeroPeriod();
    int seen = 0;
    md = 2'b10; pl = 24'd0;
    syncStart();
    for (int i = 0; i < 20; i++) begin
      sd = 12'd90; sv = 1'b1;
      @(negedge clk);
      if (rv) seen++;
    end
    sv = 1'b0;
    check("R10", seen, 0, "strobes with zero length");
  endtask

  task automatic testOneCycle();
    md = 2'b10; thr = 13'd10; pl = 24'd1;
    syncStart();
    setW(0, 50, 1);
    feedWindow(1, "R2", 1'b1, 1);
    setW(0, 5, 1);
    feedWindow(1, "R2", 1'b1, 0);
  endtask

  task automatic testSaturate();
    md2 = 2'b10; thr2 = 5'd0; pl2 = 8'd100;
    @(negedge clk);
    sy2 = 1'b1;
    @(negedge clk);
    sy2 = 1'b0;
    for (int i = 0; i < 100; i++) begin
      sd2 = 4'd3; sv2 = 1'b1;
      @(negedge clk);
    end
    sv2 = 1'b0;
    check("R7", int'(rv2), 1, "strobe at close");
    check("R7", int'(res2), 63, "saturated count");
  endtask

  initial begin
    rstN = 1'b0; sv = 1'b0; sd = '0; pl = 24'd8; thr = '0; md = 2'b00; sy = 1'b0;
    sv2 = 1'b0; sd2 = '0; pl2 = '0; thr2 = '0; md2 = 2'b00; sy2 = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    testCount();
    testPeak();
    testBackToBack();
    testReloadLength();
    testSync();
    testIdleModes();
    testZeroPeriod();
    testOneCycle();
    testSaturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule